// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker turns a 48-bit linear address into a 40-bit physical address. It reads one translation-table entry per level from a shared memory port. The walk starts from a root frame number taken from a control-register input and descends from the top-level map through the directory-pointer and directory levels to the page-table level. If a directory-pointer or directory entry marks a large page, the walk stops there, which gives 1 GB or 2 MB mappings. Otherwise the page-table entry maps a 4 KB page.

On the way down, the walker sets the accessed flag in each entry it uses. It also sets the dirty flag in the entry that maps the page, but only when the request is a write. It writes an entry back to memory only when one of these flags actually changed, and that write finishes before the next level is read. An entry whose present flag is clear ends the walk with a fault that names the level. Only one translation is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are low.
- R2: A request is accepted when `req_valid` is high and `busy` is low. `busy` then stays high until the cycle in which `done` pulses for one cycle with `busy` low. A `req_valid` seen while `busy` is high is ignored: it does not change the result or the memory traffic of the walk in flight.
- R3: The entry read at level L (3 = top map, 2 = directory pointer, 1 = directory, 0 = page table) is at the table base with bits 11:0 replaced by linear index field L shifted left by 3. Index field L is `req_lin[12+9L+8 : 12+9L]`. The level-3 base is `{root_frame, 12'h000}`. The base for each lower level is bits 39:12 of the entry just read.
- R4: An entry with bit 0 (present) clear ends the walk. `done` and `fault` are high and `fault_lvl` gives the level, using the numbering of R3. The faulting entry is not written.
- R5: Bit 7 (page size) set in a level-2 or level-1 entry ends the walk at that level. `page_size` is 2 for 1 GB, 1 for 2 MB and 0 for 4 KB. `pa_out` is entry bits 39:k joined with `req_lin` bits k-1:0, where k is 30, 21 or 12. Bit 7 is ignored at levels 3 and 0.
- R6: Bit 5 (accessed) is set in every present entry the walk reads.
- R7: Bit 6 (dirty) is set only in the final entry of a successful walk, and only when `req_write` was high.
- R8: An entry is written back, to the address it was read from, only if R6 or R7 changed it. That write completes before any further read.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay constant from the rise of `mem_req` until the cycle in which `mem_ack` is high. Any response latency is accepted.
- R10: The full 40-bit frame, including bit 39, reaches `pa_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_frame | input | 28 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request |
| req_lin | input | 48 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk ended on a non-present entry |
| fault_lvl | output | 2 | Level of the non-present entry |
| pa_out | output | 40 | Translated physical address |
| page_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 40 | Entry address |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Entry value read, valid with `mem_ack` |

## Verification
The assertions take two things for granted about the memory side:
- `mem_ack` rises only while `mem_req` is high, and for exactly one cycle.
- `req_valid` is low throughout reset.

The stimulus meets both. The bench's responder answers only a pending request. It varies the response delay between zero and three cycles, then drops the acknowledge on the next cycle. The bench raises requests only after reset. While a walk is in flight it drives a second address into `req_valid` and removes it before the walk completes. That way, the ignored request can neither be accepted nor overlap an acknowledge.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int LA_W      = 48;   // linear address width
    localparam int PA_W      = 40;   // physical address width
    localparam int OFF_W     = 12;   // 4 KB page offset width
    localparam int IDX_W     = 9;    // table index width
    localparam int NUM_LVL   = 4;    // levels in the hierarchy
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int ENT_W     = 64;   // entry width
    localparam int ENT_SHIFT = $clog2(ENT_W / 8);
    localparam int FRM_W     = PA_W - OFF_W;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_LARGE   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WBACK
    } walk_st_e;

    typedef struct packed {
        walk_st_e               st;
        logic [LVL_W-1:0]       lvl;
        logic [FRM_W-1:0]       base;
        logic [LA_W-1:0]        lin;
        logic                   wr;
        logic [ENT_W-1:0]       entry;
        logic                   done;
        logic                   fault;
        logic [LVL_W-1:0]       flvl;
        logic [PA_W-1:0]        pa;
        logic [LVL_W-1:0]       size;
    } walk_t;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int PA_W      = 40,
    parameter int LA_W      = 48,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 9,
    parameter int NUM_LVL   = 4,
    parameter int ENT_SHIFT = 3,
    localparam int LVL_W    = $clog2(NUM_LVL),
    localparam int FRM_W    = PA_W - OFF_W,
    localparam int HI_W     = LA_W - OFF_W
) (
    input  logic [FRM_W-1:0] base,
    input  logic [HI_W-1:0]  lin_hi,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  addr
);

    logic [IDX_W-1:0] idx_tab [NUM_LVL];

    // one index field per level, sliced out of the linear address
    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_idx
        assign idx_tab[lv] = lin_hi[lv*IDX_W +: IDX_W];
    end

    always_comb begin
        addr = {base, {OFF_W{1'b0}}} | (PA_W'(idx_tab[lvl]) << ENT_SHIFT);
    end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval #(
    parameter int ENT_W     = 64,
    parameter int PA_W      = 40,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 9,
    parameter int NUM_LVL   = 4,
    parameter int BIT_PRESENT = 0,
    parameter int BIT_ACC   = 5,
    parameter int BIT_DIRTY = 6,
    parameter int BIT_LARGE = 7,
    localparam int LVL_W    = $clog2(NUM_LVL),
    localparam int FRM_W    = PA_W - OFF_W
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] lvl,
    input  logic             wr,
    input  logic [PA_W-1:0]  lin_lo,
    output logic             present,
    output logic             leaf,
    output logic             changed,
    output logic [ENT_W-1:0] updated,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [FRM_W-1:0] next_base
);

    logic [PA_W-1:0] keep_tab [NUM_LVL];
    logic            large_ok [NUM_LVL];

    // low-bit masks per level and which levels may end a walk early
    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
        localparam int KEEP = OFF_W + lv * IDX_W;
        assign keep_tab[lv] = (PA_W'(1) << KEEP) - PA_W'(1);
        if (lv == 0 || lv == NUM_LVL - 1) begin : g_fixed
            assign large_ok[lv] = 1'b0;
        end else begin : g_large
            assign large_ok[lv] = 1'b1;
        end
    end

    logic [ENT_W-1:0] set_bits;

    always_comb begin
        present  = entry[BIT_PRESENT];
        leaf     = (lvl == '0) || (large_ok[lvl] && entry[BIT_LARGE]);
        set_bits = '0;
        set_bits[BIT_ACC]   = 1'b1;
        set_bits[BIT_DIRTY] = leaf && wr;
        updated   = entry | set_bits;
        changed   = (updated != entry);
        leaf_pa   = (entry[PA_W-1:0] & ~keep_tab[lvl]) | (lin_lo & keep_tab[lvl]);
        next_base = entry[PA_W-1:OFF_W];
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PA_W-OFF_W-1:0] root_frame,
    input  logic                  req_valid,
    input  logic [LA_W-1:0]       req_lin,
    input  logic                  req_write,
    output logic                  busy,
    output logic                  done,
    output logic                  fault,
    output logic [LVL_W-1:0]      fault_lvl,
    output logic [PA_W-1:0]       pa_out,
    output logic [LVL_W-1:0]      page_size,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [PA_W-1:0]       mem_addr,
    output logic [ENT_W-1:0]      mem_wdata,
    input  logic                  mem_ack,
    input  logic [ENT_W-1:0]      mem_rdata
);

    walk_t q, n;

    logic             ev_present;
    logic             ev_leaf;
    logic             ev_changed;
    logic [ENT_W-1:0] ev_updated;
    logic [PA_W-1:0]  ev_pa;
    logic [FRM_W-1:0] ev_next;
    logic [PA_W-1:0]  ent_addr;

    pt_entry_addr #(
        .PA_W(PA_W), .LA_W(LA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .NUM_LVL(NUM_LVL), .ENT_SHIFT(ENT_SHIFT)
    ) u_addr (
        .base   (q.base),
        .lin_hi (q.lin[LA_W-1:OFF_W]),
        .lvl    (q.lvl),
        .addr   (ent_addr)
    );

    pt_entry_eval #(
        .ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .NUM_LVL(NUM_LVL), .BIT_PRESENT(BIT_PRESENT), .BIT_ACC(BIT_ACC),
        .BIT_DIRTY(BIT_DIRTY), .BIT_LARGE(BIT_LARGE)
    ) u_eval (
        .entry     (q.entry),
        .lvl       (q.lvl),
        .wr        (q.wr),
        .lin_lo    (q.lin[PA_W-1:0]),
        .present   (ev_present),
        .leaf      (ev_leaf),
        .changed   (ev_changed),
        .updated   (ev_updated),
        .leaf_pa   (ev_pa),
        .next_base (ev_next)
    );

    logic req_c, we_c, advance;

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        req_c   = 1'b0;
        we_c    = 1'b0;
        advance = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    n.st   = ST_READ;
                    n.lin  = req_lin;
                    n.wr   = req_write;
                    n.base = root_frame;
                    n.lvl  = LVL_W'(NUM_LVL - 1);
                end
            end
            ST_READ: begin
                req_c = 1'b1;
                if (mem_ack) begin
                    n.entry = mem_rdata;
                    n.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!ev_present) begin
                    n.st    = ST_IDLE;
                    n.done  = 1'b1;
                    n.fault = 1'b1;
                    n.flvl  = q.lvl;
                    n.pa    = '0;
                    n.size  = '0;
                end else if (ev_changed) begin
                    n.st = ST_WBACK;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_WBACK: begin
                req_c = 1'b1;
                we_c  = 1'b1;
                if (mem_ack) advance = 1'b1;
            end
            default: n.st = ST_IDLE;
        endcase

        if (advance) begin
            if (ev_leaf) begin
                n.st    = ST_IDLE;
                n.done  = 1'b1;
                n.fault = 1'b0;
                n.flvl  = '0;
                n.pa    = ev_pa;
                n.size  = q.lvl;
            end else begin
                n.st   = ST_READ;
                n.base = ev_next;
                n.lvl  = q.lvl - LVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fault     = q.fault;
    assign fault_lvl = q.flvl;
    assign pa_out    = q.pa;
    assign page_size = q.size;
    assign mem_req   = req_c;
    assign mem_we    = we_c;
    assign mem_addr  = ent_addr;
    assign mem_wdata = ev_updated;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic        mem_req,
    input logic        mem_we,
    input logic [39:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_ack
);

    p_no_write_reset_r1: assert property (@(posedge clk) !rst_n |-> !mem_req);

    p_start_by_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_entry_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    p_fault_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> done);

    p_wb_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    p_port_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    p_req_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

    localparam logic [39:0] ROOT = 40'h00_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        busy, done, fault, mem_req, mem_we;
    logic [1:0]  fault_lvl, page_size;
    logic [39:0] pa_out, mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_frame(ROOT[39:12]),
        .req_valid(req_valid), .req_lin(req_lin), .req_write(req_write),
        .busy(busy), .done(done), .fault(fault), .fault_lvl(fault_lvl),
        .pa_out(pa_out), .page_size(page_size),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [63:0] mem     [logic [39:0]];
    logic [63:0] exp_mem [logic [39:0]];
    bit          obs_we[$], exp_we[$];
    logic [39:0] obs_addr[$], exp_addr[$];
    logic [63:0] obs_data[$], exp_data[$];

    int  errs = 0, checks = 0, cycles = 0;
    int  lat_seq = 0, wait_left = 0;
    bit  exp_busy = 0, got_done = 0;
    bit  exp_fault;
    logic [1:0]  exp_flvl, exp_size;
    logic [39:0] exp_pa;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] rd_exp(input logic [39:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 64'h0;
    endfunction

    function automatic logic [39:0] idx_of(input logic [47:0] lin, input int lv);
        return 40'((lin >> (12 + 9 * lv)) & 48'h1FF);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // one clock: memory responder, per-cycle busy comparison
    task automatic tick();
        @(negedge clk);
        cycles++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_left > 0) begin
                wait_left--;
            end else begin
                obs_we.push_back(mem_we);
                obs_addr.push_back(mem_addr);
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    obs_data.push_back(mem_wdata);
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                    obs_data.push_back(64'h0);
                end
                mem_ack   = 1'b1;
                lat_seq   = (lat_seq + 1) % 4;
                wait_left = lat_seq;
            end
        end
        if (done) begin
            got_done = 1;
            chk(!busy && exp_busy, "R2", "busy low with done", busy, 0);
            exp_busy = 0;
        end else begin
            chk(busy == exp_busy, "R2", "busy per cycle", busy, exp_busy);
        end
        if (cycles > 150000) begin
            chk(0, "R2", "watchdog", cycles, 0);
            finish_run();
        end
    endtask

    // reference walk over the expected memory image
    function automatic void model_walk(input logic [47:0] lin, input bit wr);
        logic [39:0] base, a, msk;
        logic [63:0] e, ne;
        bit leaf;
        exp_we.delete(); exp_addr.delete(); exp_data.delete();
        base = ROOT; exp_fault = 0; exp_flvl = 0; exp_pa = 0; exp_size = 0;
        for (int lv = 3; lv >= 0; lv--) begin
            a = {base[39:12], 12'h000} + idx_of(lin, lv) * 8;
            e = rd_exp(a);
            exp_we.push_back(0); exp_addr.push_back(a); exp_data.push_back(0);
            if (!e[0]) begin
                exp_fault = 1; exp_flvl = 2'(lv);
                return;
            end
            leaf = (lv == 0) || (lv < 3 && e[7]);
            ne = e | 64'h20;
            if (leaf && wr) ne = ne | 64'h40;
            if (ne != e) begin
                exp_mem[a] = ne;
                exp_we.push_back(1); exp_addr.push_back(a); exp_data.push_back(ne);
            end
            if (leaf) begin
                msk = (40'h1 << (12 + 9 * lv)) - 40'h1;
                exp_pa = (e[39:0] & ~msk) | (lin[39:0] & msk);
                exp_size = 2'(lv);
                return;
            end
            base = e[39:0];
        end
    endfunction

    task automatic put(input logic [39:0] a, input logic [63:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    function automatic logic [39:0] ent_at(input logic [47:0] lin, input int lv,
                                           input logic [39:0] tbase);
        logic [39:0] tb = (lv == 3) ? ROOT : tbase + 40'((2 - lv) * 'h1000);
        return tb + idx_of(lin, lv) * 8;
    endfunction

    task automatic build(input logic [47:0] lin, input int leaf_lv,
                         input logic [39:0] tbase, input logic [39:0] frame,
                         input logic [63:0] top_flags);
        logic [63:0] v;
        for (int lv = 3; lv >= leaf_lv; lv--) begin
            if (lv == leaf_lv)
                v = {24'h0, frame} | 64'h1 | ((lv > 0) ? 64'h80 : 64'h0);
            else
                v = {24'h0, tbase + 40'((2 - lv + 1) * 'h1000)} | 64'h1;
            if (lv == 3) v = v | top_flags;
            put(ent_at(lin, lv, tbase), v);
        end
    endtask

    task automatic clear_present(input logic [47:0] lin, input int lv,
                                 input logic [39:0] tbase);
        logic [39:0] a = ent_at(lin, lv, tbase);
        put(a, mem[a] & ~64'h1);
    endtask

    task automatic run(input logic [47:0] lin, input bit wr, input string dtag,
                       input bit noise);
        int n = 0;
        model_walk(lin, wr);
        obs_we.delete(); obs_addr.delete(); obs_data.delete();
        got_done  = 0;
        req_lin   = lin;
        req_write = wr;
        req_valid = 1'b1;
        exp_busy  = 1;
        tick();
        req_valid = 1'b0;
        if (noise) begin
            // R2: a request raised mid-walk must be ignored
            req_lin   = ~lin;
            req_write = ~wr;
            req_valid = 1'b1;
            tick(); tick();
            req_valid = 1'b0;
        end
        while (!got_done && n < 300) begin
            tick();
            n++;
        end
        if (!got_done) begin
            chk(0, "R2", "walk timed out", 0, 1);
            return;
        end
        chk(fault == exp_fault, "R4", "fault flag", fault, exp_fault);
        if (exp_fault)
            chk(fault_lvl == exp_flvl, "R4", "fault level", fault_lvl, exp_flvl);
        else begin
            chk(pa_out == exp_pa, "R5", "physical address", pa_out, exp_pa);
            chk(page_size == exp_size, "R5", "page size", page_size, exp_size);
        end
        chk(obs_we.size() == exp_we.size(), "R8", "access count",
            obs_we.size(), exp_we.size());
        if (obs_we.size() == exp_we.size()) begin
            for (int i = 0; i < exp_we.size(); i++) begin
                chk(obs_we[i] == exp_we[i], "R8", "access order", obs_we[i], exp_we[i]);
                chk(obs_addr[i] == exp_addr[i], "R3", "entry address",
                    obs_addr[i], exp_addr[i]);
                if (exp_we[i])
                    chk(obs_data[i] == exp_data[i], dtag, "written entry",
                        obs_data[i], exp_data[i]);
            end
        end
    endtask

    logic [47:0] l1, l2, l3, l4, l7, l8, l9, l10, l11;

    initial begin
        l1  = {9'd1,  9'd2,  9'd3,  9'd4,  12'h5A5};
        l2  = {9'd5,  9'd6,  9'd7,  9'd8,  12'hFFF};
        l3  = {9'd9,  9'd10, 9'd11, 9'd12, 12'h001};
        l4  = {9'd13, 9'd14, 9'd15, 9'd16, 12'hFFF};
        l7  = {9'd20, 9'd1,  9'd1,  9'd1,  12'h010};
        l8  = {9'd21, 9'd30, 9'd31, 9'd32, 12'h020};
        l9  = {9'd22, 9'd33, 9'd34, 9'd35, 12'h030};
        l10 = {9'd23, 9'd36, 9'd37, 9'd38, 12'h040};
        l11 = {9'd24, 9'd39, 9'd40, 9'd41, 12'h050};

        build(l1,  0, 40'h10_0000, 40'h12_3456_7000, 64'h0);
        build(l2,  1, 40'h20_0000, 40'hAB_CDE0_0000, 64'h0);
        build(l3,  2, 40'h30_0000, 40'hFF_C000_0000, 64'h0);
        build(l4,  0, 40'h40_0000, 40'hFF_FFFF_F000, 64'h80);
        build(l8,  0, 40'h50_0000, 40'h01_0000_0000, 64'h0);
        clear_present(l8, 2, 40'h50_0000);
        build(l9,  0, 40'h60_0000, 40'h01_0000_1000, 64'h0);
        clear_present(l9, 1, 40'h60_0000);
        build(l10, 0, 40'h70_0000, 40'h01_0000_2000, 64'h0);
        clear_present(l10, 0, 40'h70_0000);
        build(l11, 0, 40'h80_0000, 40'h05_5555_5000, 64'h0);

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "reset outputs",
            {busy, done, fault, mem_req}, 0);
        rst_n = 1'b1;
        tick();
        chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

        run(l1, 0, "R6", 0);   // 4 KB read: accessed set at all four levels
        run(l1, 0, "R8", 0);   // flags already set: no write-back
        run(l1, 1, "R7", 0);   // write: dirty only in the page-table entry
        run(l2, 1, "R7", 0);   // 2 MB write: dirty in the directory entry
        run(l3, 0, "R6", 0);   // 1 GB read
        run(l4, 1, "R5", 0);   // top-level bit 7 ignored; full-width frame
        chk(pa_out == 40'hFF_FFFF_FFFF, "R10", "top frame bits", pa_out, 40'hFF_FFFF_FFFF);
        run(l7, 0, "R4", 0);   // fault at level 3
        run(l8, 1, "R4", 0);   // fault at level 2
        run(l9, 0, "R4", 0);   // fault at level 1
        run(l10, 1, "R4", 0);  // fault at level 0
        run(l11, 0, "R6", 1);  // ignored mid-walk request, R2
        repeat (4) tick();
        chk(!busy && !mem_req, "R2", "no walk from ignored request", {busy, mem_req}, 0);
        run(l3, 1, "R7", 0);   // 1 GB write after read: only dirty write-back
        finish_run();
    end

endmodule